// File: doc/BRIEF.md
# Sign-Step Template Learning Unit

This unit holds a bank of category templates and adapts them after a classification decision. Each template is a row of unsigned weights, one per input component. When a start pulse arrives, the unit captures the input vector, the winning category, the learning mode and a flag that reports whether any category passed vigilance. It then rewrites one template row per clock cycle. It never changes a weight by a value proportional to the error. Each weight takes a step of constant size, and the step's direction is the sign of the input minus the weight.

There are three kinds of learning. In the downward-only mode, which suits fuzzy adaptive resonance, weights can only fall, so every weight starts at full scale. In vector-quantisation mode the steps go in both directions. The map mode applies the bidirectional rule to the winner and then to its two index neighbours. When the no-vigilance flag is set, the unit ignores the winner and overwrites the row selected by a round-robin pointer with the input vector (fast recoding). A combinational read port exposes any single weight.

The controller has six states:
- `ST_IDLE` waits for a start pulse. If the no-vigilance flag is set it goes to `ST_RECODE`; otherwise it goes to `ST_WIN`.
- `ST_RECODE` writes the input into the pointed row and goes to `ST_FIN`.
- `ST_WIN` steps the winner row. In map mode it then goes to `ST_LO` when a lower neighbour exists, or else to `ST_HI` when an upper neighbour exists. In every other case it goes to `ST_FIN`.
- `ST_LO` steps the row below the winner. It goes to `ST_HI` when an upper neighbour exists, otherwise to `ST_FIN`.
- `ST_HI` steps the row above the winner and goes to `ST_FIN`.
- `ST_FIN` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `sstl_learn_unit`

## Requirements
- R1: After reset every weight reads as full scale (all ones, 255 at default width), `busy` is 0 and `done` is 0.
- R2: With `mode` = 2'b00 (downward-only), only the winner row changes. A component whose input is below its weight drops by STEP. A component whose input is equal to or above its weight keeps its value.
- R3: With `mode` = 2'b01 or 2'b11 (bidirectional), only the winner row changes. Each component moves by STEP toward its input: down when the input is lower, up when the input is higher, and not at all when they are equal.
- R4: A downward step never takes a weight below 0 and an upward step never takes it above full scale. The weight clamps at that bound.
- R5: With `mode` = 2'b10 (map), rows k-1, k and k+1 get the bidirectional rule, where k is the winner. A neighbour index outside 0..M-1 is skipped, not wrapped, and all other rows are unchanged.
- R6: With `no_vig` = 1, the winner is ignored and the row at the replacement pointer is set equal to the input vector. The pointer is 0 after reset, advances by one per recode and wraps to 0 after M-1.
- R7: `busy` is high from the cycle after an accepted start until the operation ends. `done` is high for exactly one cycle, 2 clock edges after the start edge, plus one edge for each neighbour row that is stepped.
- R8: A start pulse that arrives while `busy` is high, including the `done` cycle, is ignored. Changes to `in_vec`, `win_idx`, `mode` or `no_vig` after the start edge do not affect the running operation.
- R9: Input component c occupies bits [c*W +: W] of `in_vec`. The read port returns weight `rd_comp` of row `rd_cat` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; taken only when idle |
| mode | input | 2 | 00 downward-only, 01/11 bidirectional, 10 map with neighbours |
| no_vig | input | 1 | No category was vigilant: recode the pointed row |
| win_idx | input | IW (3) | Winning category index |
| in_vec | input | N*W (32) | Input vector, component c at bits [c*W +: W] |
| rd_cat | input | IW (3) | Read port row select |
| rd_comp | input | CW (2) | Read port component select |
| rd_data | output | W (8) | Selected weight |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: a new start request, and the completion of the operation already running (or one of its neighbour steps). The bench provokes this during a map-mode update. On every busy cycle, including the one where `done` is high, it pulses `start` with a recode request, a different winner and a scrambled vector. The template rows are then compared with a model that applies only the first request. Because the recode pointer must not have moved, a later recode would land in the wrong row if a late start had been taken.

// File: rtl/sstl_pkg.sv
package sstl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECODE,
        ST_WIN,
        ST_LO,
        ST_HI,
        ST_FIN
    } sstl_state_t;

    typedef enum logic [1:0] {
        MD_DOWN = 2'b00,
        MD_BIDIR = 2'b01,
        MD_MAP = 2'b10,
        MD_BIDIR2 = 2'b11
    } sstl_mode_t;

endpackage

// File: rtl/sstl_step_cell.sv
module sstl_step_cell #(
    parameter int W = 8,
    parameter int STEP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] w,
    input  logic         down_only,
    output logic [W-1:0] w_nxt
);
    localparam logic [W-1:0] STEP_W = W'(STEP);
    localparam logic [W-1:0] FULL_W = '1;

    always_comb begin
        if (x < w) begin
            w_nxt = (w >= STEP_W) ? w - STEP_W : '0;
        end else if ((x > w) && !down_only) begin
            w_nxt = ((FULL_W - w) >= STEP_W) ? w + STEP_W : FULL_W;
        end else begin
            w_nxt = w;
        end
    end

    logic [W-1:0] delta;
    always_comb begin
        delta = (w_nxt > w) ? (w_nxt - w) : (w - w_nxt);
        a_r2_never_up: assert (!(down_only && (w_nxt > w)));
        a_r3_equal_hold: assert ((x != w) || (w_nxt == w));
        a_r4_step_bound: assert (delta <= STEP_W);
    end

endmodule

// File: rtl/sstl_row_update.sv
module sstl_row_update #(
    parameter int N = 4,
    parameter int W = 8,
    parameter int STEP = 4
) (
    input  logic [N*W-1:0] vec,
    input  logic [N*W-1:0] row_cur,
    input  logic           down_only,
    output logic [N*W-1:0] row_nxt
);
    for (genvar c = 0; c < N; c++) begin : g_cell
        sstl_step_cell #(.W(W), .STEP(STEP)) u_cell (
            .x        (vec[c*W +: W]),
            .w        (row_cur[c*W +: W]),
            .down_only(down_only),
            .w_nxt    (row_nxt[c*W +: W])
        );
    end

endmodule

// File: rtl/sstl_template_bank.sv
module sstl_template_bank #(
    parameter int M = 8,
    parameter int N = 4,
    parameter int W = 8,
    parameter int IW = 3,
    parameter int CW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_row,
    input  logic [N*W-1:0] wr_data,
    output logic [N*W-1:0] row_data,
    input  logic [IW-1:0]  rd_cat,
    input  logic [CW-1:0]  rd_comp,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] mem [M][N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < M; r++) begin
                for (int c = 0; c < N; c++) begin
                    mem[r][c] <= '1;
                end
            end
        end else if (wr_en && (wr_row <= IW'(M-1))) begin
            for (int c = 0; c < N; c++) begin
                mem[wr_row][c] <= wr_data[c*W +: W];
            end
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_rd
        assign row_data[c*W +: W] = mem[wr_row][c];
    end

    assign rd_data = mem[rd_cat][rd_comp];

endmodule

// File: rtl/sstl_ctrl.sv
module sstl_ctrl
    import sstl_pkg::*;
#(
    parameter int M = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          no_vig,
    input  logic [1:0]    mode,
    input  logic [IW-1:0] win_idx,
    output logic          take,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic          recode,
    output logic [IW-1:0] wr_row,
    output logic          down_only
);
    localparam logic [IW-1:0] LAST = IW'(M-1);

    sstl_state_t   state, nxt;
    logic [IW-1:0] win_q;
    logic [IW-1:0] rr_q;
    sstl_mode_t    mode_q;
    logic          map_q;

    assign take      = start && (state == ST_IDLE);
    assign map_q     = (mode_q == MD_MAP);
    assign down_only = (mode_q == MD_DOWN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            mode_q <= MD_DOWN;
            rr_q   <= '0;
        end else begin
            if (take) begin
                win_q  <= win_idx;
                mode_q <= sstl_mode_t'(mode);
            end
            if (state == ST_RECODE) begin
                rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = no_vig ? ST_RECODE : ST_WIN;
            ST_RECODE: nxt = ST_FIN;
            ST_WIN: begin
                if (map_q && (win_q != '0))      nxt = ST_LO;
                else if (map_q && (win_q != LAST)) nxt = ST_HI;
                else                              nxt = ST_FIN;
            end
            ST_LO:     nxt = (win_q != LAST) ? ST_HI : ST_FIN;
            ST_HI:     nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state != ST_IDLE);
        done   = 1'b0;
        wr_en  = 1'b0;
        recode = 1'b0;
        wr_row = win_q;
        unique case (state)
            ST_IDLE: ;
            ST_RECODE: begin
                wr_en  = 1'b1;
                recode = 1'b1;
                wr_row = rr_q;
            end
            ST_WIN: wr_en = 1'b1;
            ST_LO: begin
                wr_en  = 1'b1;
                wr_row = win_q - 1'b1;
            end
            ST_HI: begin
                wr_en  = 1'b1;
                wr_row = win_q + 1'b1;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (win_q == $past(win_q)) && (mode_q == $past(mode_q)));
    a_r5_low_exists: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO) |-> (win_q != '0));
    a_r5_high_exists: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI) |-> (win_q != LAST));
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RECODE) |=> $stable(rr_q));

endmodule

// File: rtl/sstl_learn_unit.sv
module sstl_learn_unit #(
    parameter int M = 8,
    parameter int N = 4,
    parameter int W = 8,
    parameter int STEP = 4,
    localparam int IW = (M > 1) ? $clog2(M) : 1,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic           no_vig,
    input  logic [IW-1:0]  win_idx,
    input  logic [N*W-1:0] in_vec,
    input  logic [IW-1:0]  rd_cat,
    input  logic [CW-1:0]  rd_comp,
    output logic [W-1:0]   rd_data,
    output logic           busy,
    output logic           done
);
    logic           take, wr_en, recode, down_only;
    logic [IW-1:0]  wr_row;
    logic [N*W-1:0] vec_q, row_cur, row_nxt, wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (take) begin
            vec_q <= in_vec;
        end
    end

    sstl_ctrl #(.M(M), .IW(IW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .no_vig   (no_vig),
        .mode     (mode),
        .win_idx  (win_idx),
        .take     (take),
        .busy     (busy),
        .done     (done),
        .wr_en    (wr_en),
        .recode   (recode),
        .wr_row   (wr_row),
        .down_only(down_only)
    );

    sstl_row_update #(.N(N), .W(W), .STEP(STEP)) u_upd (
        .vec      (vec_q),
        .row_cur  (row_cur),
        .down_only(down_only),
        .row_nxt  (row_nxt)
    );

    assign wr_data = recode ? vec_q : row_nxt;

    sstl_template_bank #(.M(M), .N(N), .W(W), .IW(IW), .CW(CW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .row_data(row_cur),
        .rd_cat  (rd_cat),
        .rd_comp (rd_comp),
        .rd_data (rd_data)
    );

    a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vec_q));

endmodule

// File: tb/sstl_learn_unit_test.sv
`timescale 1ns/1ps
module sstl_learn_unit_test;
    localparam int M = 8;
    localparam int N = 4;
    localparam int W = 8;
    localparam int NT = 10;

    // entry: {mode[1:0], no_vig, win[2:0], comp3, comp2, comp1, comp0}
    localparam logic [37:0] TBL [NT] = '{
        {2'd0, 1'b0, 3'd2, 8'd255, 8'd10,  8'd255, 8'd200},
        {2'd0, 1'b1, 3'd6, 8'd200, 8'd150, 8'd50,  8'd100},
        {2'd1, 1'b0, 3'd0, 8'd0,   8'd150, 8'd40,  8'd120},
        {2'd1, 1'b1, 3'd0, 8'd3,   8'd128, 8'd250, 8'd5},
        {2'd2, 1'b0, 3'd1, 8'd128, 8'd128, 8'd255, 8'd0},
        {2'd2, 1'b0, 3'd0, 8'd60,  8'd60,  8'd60,  8'd60},
        {2'd3, 1'b0, 3'd5, 8'd255, 8'd255, 8'd0,   8'd0},
        {2'd0, 1'b0, 3'd0, 8'd0,   8'd255, 8'd0,   8'd255},
        {2'd2, 1'b0, 3'd7, 8'd40,  8'd30,  8'd20,  8'd10},
        {2'd0, 1'b0, 3'd3, 8'd255, 8'd255, 8'd255, 8'd255}
    };

    logic clk = 0, rst_n = 0, start = 0, no_vig = 0;
    logic [1:0] mode = 0;
    logic [2:0] win_idx = 0, rd_cat = 0;
    logic [1:0] rd_comp = 0;
    logic [31:0] in_vec = 0;
    logic [7:0] rd_data;
    logic busy, done;

    int total = 0, bad = 0, rr = 0;
    int exp_w [M][N];

    always #10 clk = ~clk;

    sstl_learn_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .no_vig(no_vig),
        .win_idx(win_idx), .in_vec(in_vec), .rd_cat(rd_cat), .rd_comp(rd_comp),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic rd(input int r, input int c, output int v);
        rd_cat = r[2:0];
        rd_comp = c[1:0];
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_rows(input string tag);
        for (int r = 0; r < M; r++) begin
            int v, a, e;
            bit ok;
            ok = 1; a = 0; e = 0;
            for (int c = 0; c < N; c++) begin
                rd(r, c, v);
                a = (a << 8) | v;
                e = (e << 8) | exp_w[r][c];
                if (v != exp_w[r][c]) ok = 0;
            end
            check(ok, tag, $sformatf("row %0d (comp0 in high byte)", r), a, e);
        end
    endtask

    function automatic int mstep(input int md, input int x, input int w);
        if (x < w) return (w >= 4) ? w - 4 : 0;
        if (x > w && md != 0) return (255 - w >= 4) ? w + 4 : 255;
        return w;
    endfunction

    task automatic model(input int md, input int nv, input int win, input logic [31:0] vec);
        if (nv != 0) begin
            for (int c = 0; c < N; c++) exp_w[rr][c] = int'(vec[c*8 +: 8]);
            rr = (rr + 1) % M;
        end else begin
            for (int c = 0; c < N; c++) exp_w[win][c] = mstep(md, int'(vec[c*8 +: 8]), exp_w[win][c]);
            if (md == 2 && win > 0)
                for (int c = 0; c < N; c++) exp_w[win-1][c] = mstep(md, int'(vec[c*8 +: 8]), exp_w[win-1][c]);
            if (md == 2 && win < M-1)
                for (int c = 0; c < N; c++) exp_w[win+1][c] = mstep(md, int'(vec[c*8 +: 8]), exp_w[win+1][c]);
        end
    endtask

    task automatic run_op(input int md, input int nv, input int win,
                          input logic [31:0] vec, input bit pester, input string tag);
        int lat, cnt;
        bit seen;
        lat = (nv != 0) ? 2 : 2 + ((md == 2 && win > 0) ? 1 : 0) + ((md == 2 && win < M-1) ? 1 : 0);
        @(negedge clk);
        start = 1; mode = md[1:0]; no_vig = nv[0]; win_idx = win[2:0]; in_vec = vec;
        cnt = 0; seen = 0;
        while (!seen && cnt < 20) begin
            @(negedge clk);
            // R8: disturb inputs while busy; pester also re-raises start
            start = pester; no_vig = 1; mode = 2'd1;
            win_idx = ~win_idx; in_vec = ~vec;
            cnt++;
            if (cnt == 1) check(busy == 1, "R7", "busy after start", int'(busy), 1);
            if (done) seen = 1;
        end
        check(seen && cnt == lat, "R7", "done latency", cnt, lat);
        @(negedge clk);
        start = 0;
        check(done == 0 && busy == 0, "R7", "done single cycle", int'(done), 0);
        model(md, nv, win, vec);
        check_rows(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < M; r++)
            for (int c = 0; c < N; c++) exp_w[r][c] = 255;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy in reset", int'(busy), 0);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1", "flags after reset", int'(busy) + int'(done), 0);
        check_rows("R1");

        // table walk: R2 R3 R5 R6 (R9 field layout used throughout)
        for (int i = 0; i < NT; i++) begin
            int md, nv, wn;
            string tg;
            md = int'(TBL[i][37:36]);
            nv = int'(TBL[i][35]);
            wn = int'(TBL[i][34:32]);
            tg = (nv != 0) ? "R6" : (md == 0) ? "R2" : (md == 2) ? "R5" : "R3";
            run_op(md, nv, wn, TBL[i][31:0], 1'b0, tg);
        end

        // R4: saturation at both bounds; literal expectations
        begin
            int row, v;
            row = rr;
            run_op(0, 1, 0, {8'd255, 8'd0, 8'd253, 8'd2}, 1'b0, "R6");
            run_op(1, 0, row, {8'd0, 8'd255, 8'd255, 8'd0}, 1'b0, "R4");
            rd(row, 0, v); check(v == 0, "R4", "clamp at zero", v, 0);
            rd(row, 1, v); check(v == 255, "R4", "clamp at full scale", v, 255);
            rd(row, 2, v); check(v == 4, "R4", "step up from zero", v, 4);
            rd(row, 3, v); check(v == 251, "R4", "step down from full", v, 251);
        end

        // R8: start pulses during every busy cycle including done
        run_op(2, 0, 3, {8'd90, 8'd200, 8'd17, 8'd250}, 1'b1, "R8");

        // R6: pointer wrap across the whole range
        for (int k = 0; k < M + 1; k++) begin
            run_op(0, 1, 7 - (k % M), {8'(k), 8'(3*k), 8'(k+100), 8'(200-k)}, 1'b0, "R6");
        end

        // R9: single-component read addressing
        begin
            int v;
            rd(rr == 0 ? M-1 : rr-1, 2, v);
            check(v == exp_w[rr == 0 ? M-1 : rr-1][2], "R9", "component 2 read", v,
                  exp_w[rr == 0 ? M-1 : rr-1][2]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule